// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the integer register file of a processor core: 32 entries of 64 bits, two combinational read ports and one synchronous write port. Eight of the entries (indices 8 to 14 and 25) exist twice, once in a common bank and once in a shadow bank. A mode bit, `shadow_active`, selects which copy those eight indices reach. All other indices always reach the common bank. Index 31 is a hard-wired zero.

Privileged firmware runs with the mode set, so it gets eight scratch registers of its own without saving the interrupted program's values. An external trap sequencer pulses `shadow_enter` when firmware is entered and `shadow_exit` when it returns. Switching only flips the select bit; no data moves, so both copies survive any number of switches. A request that does not fit the current mode is refused and recorded in a sticky error flag.

The block leaves reset with the mode already set, as a core does when it starts in firmware.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low and right after it is released, `shadow_active` is 1, `mode_err` is 0 and every read port returns zero.
- R2: Indices 0 to 7, 15 to 24 and 26 to 30 reach one common storage entry. A value written there reads back the same whether `shadow_active` is 0 or 1.
- R3: Indices 8 to 14 and 25 reach the shadow copy while `shadow_active` is 1 and the common copy while it is 0. This holds for both reads and writes.
- R4: Switching the mode moves no data. Each copy of a banked index keeps its value across any number of mode switches.
- R5: A `shadow_enter` request while `shadow_active` is 1, or a `shadow_exit` request while it is 0, sets `mode_err` on the next rising edge and leaves `shadow_active` unchanged.
- R6: A lone `shadow_enter` while the mode is 0 sets `shadow_active` on the next rising edge. A lone `shadow_exit` while it is 1 clears it. With no request, the mode holds.
- R7: When a write and a mode change fall in the same cycle, the write goes to the copy selected before the change.
- R8: Index 31 always reads as zero, and writes to it change nothing.
- R9: The read ports are combinational from the index inputs. A write becomes visible on the read ports after the rising edge that takes it, and not before.
- R10: `shadow_enter` and `shadow_exit` high in the same cycle is an error. It sets `mode_err` and leaves the mode unchanged.
- R11: Once set, `mode_err` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write port, mode and error flag update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 64 | Data for read port A, combinational |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 64 | Data for read port B, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 64 | Data to write |
| shadow_enter | input | 1 | Request to set the shadow mode |
| shadow_exit | input | 1 | Request to clear the shadow mode |
| shadow_active | output | 1 | Current mode; 1 routes the banked indices to the shadow copies |
| mode_err | output | 1 | Sticky flag for an invalid mode request |

## Verification
The bench builds the block with its default parameters: 32 entries of 64 bits, the bank mask on indices 8 to 14 and 25, and index 31 as zero. With these values every index is reachable from a 5-bit port, so each banked and unbanked neighbour (7/8, 14/15, 24/25/26, 30/31) can be hit directly. Directed runs cover a write that lands in the same cycle as a mode change, and each of the three invalid request kinds, each from a fresh reset. A long random run then switches modes often while writing both banks, so values must survive in each copy across many switches.

// File: rtl/brf_pkg.sv
package brf_pkg;
  parameter int unsigned BRF_XLEN     = 64;
  parameter int unsigned BRF_NREG     = 32;
  parameter int unsigned BRF_ZERO_IDX = 31;
  // One bit per register index; a set bit means the index has a shadow copy.
  parameter logic [31:0] BRF_BANK_MASK = 32'h0200_7F00;

  typedef enum logic {
    BRF_MODE_NORMAL = 1'b0,
    BRF_MODE_SHADOW = 1'b1
  } brf_mode_e;
endpackage

// File: rtl/brf_mode_ctrl.sv
module brf_mode_ctrl
  import brf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_req,
  input  logic exit_req,
  output logic shadow_on,
  output logic err_flag
);
  brf_mode_e mode_q, mode_d;
  logic      err_q, err_d;
  logic      req_any;
  logic      req_bad;

  assign req_any = enter_req | exit_req;
  assign req_bad = (enter_req & exit_req)
                 | (enter_req & (mode_q == BRF_MODE_SHADOW))
                 | (exit_req  & (mode_q == BRF_MODE_NORMAL));

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (req_bad) begin
      err_d = 1'b1;
    end else if (enter_req) begin
      mode_d = BRF_MODE_SHADOW;
    end else if (exit_req) begin
      mode_d = BRF_MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BRF_MODE_SHADOW;
      err_q  <= 1'b0;
    end else if (req_any) begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign shadow_on = (mode_q == BRF_MODE_SHADOW);
  assign err_flag  = err_q;
endmodule

// File: rtl/brf_bank.sv
module brf_bank #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NREG    = 32,
  parameter logic [NREG-1:0] PRESENT = '1,
  localparam int unsigned AW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_a_idx,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_a_data,
  output logic [XLEN-1:0] rd_b_data
);
  logic [XLEN-1:0] ent [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (PRESENT[i]) begin : g_store
      logic [XLEN-1:0] q;
      logic            hit;
      assign hit = wr_en && (wr_idx == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wr_data;
        end
      end
      assign ent[i] = q;
    end else begin : g_none
      assign ent[i] = '0;
    end
  end

  assign rd_a_data = ent[rd_a_idx];
  assign rd_b_data = ent[rd_b_idx];
endmodule

// File: rtl/brf_port_sel.sv
module brf_port_sel #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  parameter logic [NREG-1:0] BANK_MASK = '0,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic [AW-1:0]   idx,
  input  logic            shadow_on,
  input  logic [XLEN-1:0] com_data,
  input  logic [XLEN-1:0] shd_data,
  output logic [XLEN-1:0] data
);
  always_comb begin
    if (shadow_on && BANK_MASK[idx]) begin
      data = shd_data;
    end else begin
      data = com_data;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned XLEN     = BRF_XLEN,
  parameter int unsigned NREG     = BRF_NREG,
  parameter int unsigned ZERO_IDX = BRF_ZERO_IDX,
  parameter logic [NREG-1:0] BANK_MASK = NREG'(BRF_BANK_MASK),
  localparam int unsigned AW      = $clog2(NREG),
  localparam logic [NREG-1:0] COMMON_MASK = ~(NREG'(1) << ZERO_IDX),
  localparam logic [NREG-1:0] SHADOW_MASK = BANK_MASK & COMMON_MASK
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            shadow_enter,
  input  logic            shadow_exit,
  output logic            shadow_active,
  output logic            mode_err
);
  logic            wr_live;
  logic            wr_to_shadow;
  logic            com_we;
  logic            shd_we;
  logic [XLEN-1:0] com_a, com_b, shd_a, shd_b;

  brf_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_req (shadow_enter),
    .exit_req  (shadow_exit),
    .shadow_on (shadow_active),
    .err_flag  (mode_err)
  );

  // Steering uses the mode as registered, i.e. before any toggle this cycle.
  assign wr_live      = wr_en && (wr_idx != AW'(ZERO_IDX));
  assign wr_to_shadow = shadow_active && SHADOW_MASK[wr_idx];
  assign com_we       = wr_live && !wr_to_shadow;
  assign shd_we       = wr_live && wr_to_shadow;

  brf_bank #(.XLEN(XLEN), .NREG(NREG), .PRESENT(COMMON_MASK)) u_common (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (com_we),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .rd_a_data (com_a),
    .rd_b_data (com_b)
  );

  brf_bank #(.XLEN(XLEN), .NREG(NREG), .PRESENT(SHADOW_MASK)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (shd_we),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .rd_a_data (shd_a),
    .rd_b_data (shd_b)
  );

  brf_port_sel #(.XLEN(XLEN), .NREG(NREG), .BANK_MASK(SHADOW_MASK)) u_sel_a (
    .idx       (rd_a_idx),
    .shadow_on (shadow_active),
    .com_data  (com_a),
    .shd_data  (shd_a),
    .data      (rd_a_data)
  );

  brf_port_sel #(.XLEN(XLEN), .NREG(NREG), .BANK_MASK(SHADOW_MASK)) u_sel_b (
    .idx       (rd_b_idx),
    .shadow_on (shadow_active),
    .com_data  (com_b),
    .shd_data  (shd_b),
    .data      (rd_b_data)
  );
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NREG     = 32,
  parameter int unsigned ZERO_IDX = 31,
  parameter logic [NREG-1:0] BANK_MASK = '0,
  localparam int unsigned AW      = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [AW-1:0]   rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [AW-1:0]   wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            shadow_enter,
  input logic            shadow_exit,
  input logic            shadow_active,
  input logic            mode_err
);
  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == AW'(ZERO_IDX)) |-> (rd_a_data == '0)); // R8

  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == AW'(ZERO_IDX)) |-> (rd_b_data == '0)); // R8

  AST_BAD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_enter && shadow_active) |=> (mode_err && $stable(shadow_active))); // R5

  AST_BAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_exit && !shadow_active) |=> (mode_err && $stable(shadow_active))); // R5

  AST_BOTH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_enter && shadow_exit) |=> (mode_err && $stable(shadow_active))); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err); // R11

  AST_GOOD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_enter && !shadow_exit && !shadow_active) |=> shadow_active); // R6

  AST_GOOD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_exit && !shadow_enter && shadow_active) |=> !shadow_active); // R6

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_enter && !shadow_exit) |=> $stable(shadow_active)); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != AW'(ZERO_IDX)) && !shadow_enter && !shadow_exit)
    |=> ((rd_a_idx == $past(wr_idx)) -> (rd_a_data == $past(wr_data)))); // R9

  AST_UNBANKED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((shadow_active != $past(shadow_active)) && !$past(wr_en)
     && $stable(rd_a_idx) && !BANK_MASK[rd_a_idx])
    |-> $stable(rd_a_data)); // R2
endmodule

bind banked_regfile brf_checker #(
  .XLEN(XLEN), .NREG(NREG), .ZERO_IDX(ZERO_IDX), .BANK_MASK(BANK_MASK)
) u_brf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_a_idx      (rd_a_idx),
  .rd_a_data     (rd_a_data),
  .rd_b_idx      (rd_b_idx),
  .rd_b_data     (rd_b_data),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .shadow_enter  (shadow_enter),
  .shadow_exit   (shadow_exit),
  .shadow_active (shadow_active),
  .mode_err      (mode_err)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, shadow_enter = 1'b0, shadow_exit = 1'b0;
  logic        shadow_active, mode_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .shadow_enter(shadow_enter), .shadow_exit(shadow_exit),
    .shadow_active(shadow_active), .mode_err(mode_err)
  );

  // Behavioural reference
  logic [63:0] m_com [32];
  logic [63:0] m_shd [32];
  bit m_mode, m_err;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  function automatic bit has_copy(int i);
    return (i >= 8 && i <= 14) || i == 25;
  endfunction

  function automatic logic [63:0] m_read(int i);
    if (i == 31) return 64'd0;
    if (m_mode && has_copy(i)) return m_shd[i];
    return m_com[i];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_com[i] = '0;
      m_shd[i] = '0;
    end
    m_mode = 1'b1;
    m_err  = 1'b0;
  endtask

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    cmp(tag, "rd_a_data", rd_a_data, m_read(int'(rd_a_idx)));
    cmp(tag, "rd_b_data", rd_b_data, m_read(int'(rd_b_idx)));
    cmp(tag, "shadow_active", {63'd0, shadow_active}, {63'd0, m_mode});
    cmp(tag, "mode_err", {63'd0, mode_err}, {63'd0, m_err});
  endtask

  task automatic step(string tag, bit we, int wi, logic [63:0] wd,
                      int ra, int rb, bit en, bit ex);
    @(negedge clk);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    shadow_enter = en; shadow_exit = ex;
    #1;
    compare_all(tag);
    // Model the coming rising edge: write uses the mode before any toggle
    if (we && wi != 31) begin
      if (m_mode && has_copy(wi)) m_shd[wi] = wd;
      else m_com[wi] = wd;
    end
    if (en && ex) m_err = 1'b1;
    else if (en) begin
      if (m_mode) m_err = 1'b1; else m_mode = 1'b1;
    end else if (ex) begin
      if (!m_mode) m_err = 1'b1; else m_mode = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 0; shadow_enter = 0; shadow_exit = 0;
    rd_a_idx = 5'd9; rd_b_idx = 5'd3;
    model_reset();
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1: state right after release
    step("R1", 0, 0, 0, 25, 14, 0, 0);
    // R8: index 31 ignores writes, reads zero
    step("R8", 1, 31, 64'hDEAD_BEEF_0000_0031, 31, 31, 0, 0);
    step("R8", 0, 0, 0, 31, 30, 0, 0);
    // R9: write then read same cycle shows old value, next cycle new
    step("R9", 1, 9, 64'hAAAA_0000_0000_0009, 9, 8, 0, 0);
    step("R9", 0, 0, 0, 9, 8, 0, 0);
    // R3: shadow copy of 9 written; leave shadow mode, common copy is zero
    step("R6", 0, 0, 0, 9, 3, 0, 1);
    step("R3", 0, 0, 0, 9, 25, 0, 0);
    step("R3", 1, 9, 64'hBBBB_0000_0000_0009, 9, 14, 0, 0);
    step("R3", 1, 3, 64'h3333_0000_0000_0003, 9, 3, 0, 0);
    // R4 / R2: switch in and out, each copy kept, unbanked unchanged
    step("R6", 0, 0, 0, 9, 3, 1, 0);
    step("R4", 0, 0, 0, 9, 3, 0, 0);
    step("R2", 0, 0, 0, 3, 9, 0, 1);
    step("R4", 0, 0, 0, 9, 3, 0, 0);
    // R7: write to 25 in the same cycle as entering -> lands in common copy
    step("R7", 1, 25, 64'hC0C0_0000_0000_0025, 25, 24, 1, 0);
    step("R7", 0, 0, 0, 25, 26, 0, 0);
    step("R7", 1, 8, 64'h8888_0000_0000_0008, 8, 15, 0, 1);
    step("R7", 0, 0, 0, 25, 8, 0, 0);
    // R5: exit while already out
    step("R5", 0, 0, 0, 9, 25, 0, 1);
    step("R5", 0, 0, 0, 9, 25, 0, 0);
    // R11: flag holds over further valid traffic
    for (int k = 0; k < 5; k++) step("R11", 1, k, 64'(k + 100), k, 9, k == 2, 0);
    do_reset();
    // R5: enter while already in
    step("R5", 0, 0, 0, 10, 25, 1, 0);
    step("R5", 0, 0, 0, 10, 25, 0, 0);
    do_reset();
    // R10: both requests together
    step("R10", 0, 0, 0, 11, 7, 1, 1);
    step("R10", 0, 0, 0, 11, 7, 0, 0);
    step("R11", 0, 0, 0, 11, 7, 0, 0);
    do_reset();
    // R4: random traffic with frequent legal switches
    for (int k = 0; k < 4000; k++) begin
      bit tog;
      tog = ($urandom_range(0, 5) == 0);
      step("R4", $urandom_range(0, 1) == 1, $urandom_range(0, 31),
           {$urandom, $urandom}, $urandom_range(0, 31), $urandom_range(0, 31),
           tog && !m_mode, tog && m_mode);
    end
    step("R4", 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule